// File: doc/BRIEF.md
# Serial DAC Command Interface

This block is the slave-side serial front end of a 13-bit digital-to-analog converter. A host lowers chip select, sends sixteen bits MSB-first on the data line, and clocks each bit in on the rising edge of the serial clock. The host then raises chip select. The first three bits of a frame are a command code and the remaining thirteen are a data payload. A frame is carried out only when exactly sixteen rising clock edges were seen while chip select was low. Any other frame is dropped.

The block holds an input register and a DAC register, which feed the converter core. It also holds a user-programmable output pin, a power-down flag and a data-out edge mode. The shift register is echoed on the data-out pin so that devices can be daisy-chained or read back. In the default mode, data-out changes on the falling serial-clock edge, which gives a 16-clock lag. In the alternative mode it changes on the rising edge, which gives a 15.5-clock lag.

While powered down, data-out and the user output keep their last levels. A wake-up command issued while the active-low clear input is held low returns the user output to its default level. All serial pins are synchronised to a fast system clock and handled by edge detection.

Top module: `serdac_if`

## Requirements
- R1: After reset, dout, upo and powerDown are 0, inputReg and dacReg are 0, and data-out mode is falling-edge (mode 0).
- R2: A frame is 16 bits MSB-first, with bits [15:13] as the command and bits [12:0] as the payload. Command 3'b001 loads the payload into inputReg and leaves dacReg unchanged.
- R3: Command 3'b010 loads the payload into both inputReg and dacReg.
- R4: Command 3'b011 copies inputReg into dacReg and leaves inputReg unchanged.
- R5: A frame with a rising-edge count other than 16 (for example 15 or 17) changes no register.
- R6: In mode 0, dout changes only after falling sclk edges. While the host clocks frame N+1, the level seen after rising edge k (k = 1..16) is bit 16-k of frame N.
- R7: Command 3'b100 sets the data-out mode from payload bit 12 (1 = rising-edge mode). In rising-edge mode, the level seen after rising edge k of frame N+1 is bit 15-k of frame N.
- R8: Command 3'b101 sets upo to payload bit 12.
- R9: Command 3'b110 sets powerDown. While powerDown is set, dout keeps its level and a 3'b101 command leaves upo unchanged.
- R10: Command 3'b111 clears powerDown. If clrN is low at that time, upo goes to 0; otherwise upo is kept.
- R11: While csN is high, sclk edges neither shift data nor change dout, and they do not count toward the next frame.
- R12: Command 3'b000 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial pins |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select; its rising edge executes a frame |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial data in, sampled on the rising sclk edge |
| clrN | input | 1 | Active-low clear, applied to upo on wake-up |
| dout | output | 1 | Serial echo of the shift register |
| upo | output | 1 | User-programmable output pin |
| powerDown | output | 1 | High while the converter is powered down |
| inputReg | output | 13 | Input (staging) register |
| dacReg | output | 13 | Register that drives the converter core |

## Verification
The assertions assume the host keeps each sclk level and each din value stable for several system clocks, so that the synchroniser and edge detector see every edge exactly once. They also assume that din is settled before each rising sclk edge and that csN does not move at the same time as sclk. The bench holds each sclk phase for ten system clocks. It changes din only right after a falling edge, and it places chip-select changes a full half-period away from any clock edge. The bench samples dout halfway through each high phase, which separates the two data-out modes by half a serial clock.

// File: rtl/serdac_pkg.sv
package serdac_pkg;

  localparam int CMD_W = 3;

  typedef enum logic [CMD_W-1:0] {
    CMD_NOP       = 3'b000,
    CMD_LOAD_IN   = 3'b001,
    CMD_LOAD_BOTH = 3'b010,
    CMD_XFER      = 3'b011,
    CMD_MODE      = 3'b100,
    CMD_UPO       = 3'b101,
    CMD_SLEEP     = 3'b110,
    CMD_WAKE      = 3'b111
  } cmd_e;

  // Strobes and qualified pin levels passed from control to datapath
  typedef struct packed {
    logic shift;   // rising sclk while selected
    logic fall;    // falling sclk while selected
    logic exec;    // frame of correct length completed
    logic csIdle;  // chip select is inactive
    logic dinBit;  // synchronised serial data
    logic clrLow;  // synchronised clear is asserted
  } strobe_t;

endpackage

// File: rtl/serdac_sync.sv
module serdac_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int CHAIN_W = WIDTH * STAGES;

  logic [CHAIN_W-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {STAGES{RST_VAL}};
    else       chain <= {chain[CHAIN_W-WIDTH-1:0], d};
  end

  assign q = chain[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/serdac_ctrl.sv
module serdac_ctrl
  import serdac_pkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    csN,
  input  logic    sclk,
  input  logic    din,
  input  logic    clrN,
  output strobe_t stb
);
  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

  logic [3:0] pinSync;
  logic csS, sclkS, dinS, clrS;
  logic sclkPrev, csPrev;
  logic riseEdge, fallEdge, csRise;
  logic [CNT_W-1:0] bitCnt;

  serdac_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1001)) pinSync_i (
    .clk (clk),
    .rstN(rstN),
    .d   ({csN, sclk, din, clrN}),
    .q   (pinSync)
  );

  assign {csS, sclkS, dinS, clrS} = pinSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev <= 1'b0;
      csPrev   <= 1'b1;
    end else begin
      sclkPrev <= sclkS;
      csPrev   <= csS;
    end
  end

  assign riseEdge = sclkS & ~sclkPrev & ~csS;
  assign fallEdge = ~sclkS & sclkPrev & ~csS;
  assign csRise   = csS & ~csPrev;

  // Edge count saturates one past a full frame so over-long frames fail
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              bitCnt <= '0;
    else if (csS)                           bitCnt <= '0;
    else if (riseEdge && bitCnt != CNT_OVER) bitCnt <= bitCnt + 1'b1;
  end

  always_comb begin
    stb.shift  = riseEdge;
    stb.fall   = fallEdge;
    stb.exec   = csRise && (bitCnt == CNT_FULL);
    stb.csIdle = csS;
    stb.dinBit = dinS;
    stb.clrLow = ~clrS;
  end

  // R5: the count restarts every time the device is deselected
  a_r5_count_restart: assert property (@(posedge clk) disable iff (!rstN)
    csS |=> (bitCnt == '0));

endmodule

// File: rtl/serdac_datapath.sv
module serdac_datapath
  import serdac_pkg::*;
#(
  parameter int DATA_W = 13,
  parameter logic UPO_DEFAULT = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  output logic              dout,
  output logic              upo,
  output logic              powerDown,
  output logic [DATA_W-1:0] inputReg,
  output logic [DATA_W-1:0] dacReg
);
  localparam int FRAME_W = CMD_W + DATA_W;

  logic [FRAME_W-1:0] shiftReg;
  logic               modeRise;
  cmd_e               cmd;
  logic [DATA_W-1:0]  payload;

  assign cmd     = cmd_e'(shiftReg[FRAME_W-1 -: CMD_W]);
  assign payload = shiftReg[DATA_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          shiftReg <= '0;
    else if (stb.shift) shiftReg <= {shiftReg[FRAME_W-2:0], stb.dinBit};
  end

  // Rising mode launches the bit that becomes MSB after this shift
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dout <= 1'b0;
    end else if (!powerDown) begin
      if (modeRise && stb.shift)      dout <= shiftReg[FRAME_W-2];
      else if (!modeRise && stb.fall) dout <= shiftReg[FRAME_W-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inputReg  <= '0;
      dacReg    <= '0;
      modeRise  <= 1'b0;
      upo       <= UPO_DEFAULT;
      powerDown <= 1'b0;
    end else if (stb.exec) begin
      case (cmd)
        CMD_LOAD_IN:   inputReg <= payload;
        CMD_LOAD_BOTH: begin
          inputReg <= payload;
          dacReg   <= payload;
        end
        CMD_XFER:      dacReg   <= inputReg;
        CMD_MODE:      modeRise <= payload[DATA_W-1];
        CMD_UPO:       if (!powerDown) upo <= payload[DATA_W-1];
        CMD_SLEEP:     powerDown <= 1'b1;
        CMD_WAKE: begin
          powerDown <= 1'b0;
          if (stb.clrLow) upo <= UPO_DEFAULT;
        end
        default: ;
      endcase
    end
  end

  // R9: serial echo frozen while powered down
  a_r9_dout_frozen: assert property (@(posedge clk) disable iff (!rstN)
    powerDown |=> $stable(dout));

  // R9: user output frozen while powered down, except by a wake frame
  a_r9_upo_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (powerDown && !stb.exec) |=> $stable(upo));

  // R11: deselected device keeps its shift register
  a_r11_idle_no_shift: assert property (@(posedge clk) disable iff (!rstN)
    stb.csIdle |=> $stable(shiftReg));

  // R4: DAC register moves only when a frame executes
  a_r4_dac_needs_exec: assert property (@(posedge clk) disable iff (!rstN)
    !stb.exec |=> $stable(dacReg));

  // R6: echo moves only after a serial clock edge
  a_r6_dout_on_edge: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.shift || stb.fall) |=> $stable(dout));

endmodule

// File: rtl/serdac_if.sv
module serdac_if
  import serdac_pkg::*;
#(
  parameter int DATA_W = 13,
  parameter int SYNC_STAGES = 2,
  parameter logic UPO_DEFAULT = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              din,
  input  logic              clrN,
  output logic              dout,
  output logic              upo,
  output logic              powerDown,
  output logic [DATA_W-1:0] inputReg,
  output logic [DATA_W-1:0] dacReg
);
  localparam int FRAME_W = CMD_W + DATA_W;

  strobe_t stb;

  serdac_ctrl #(.FRAME_W(FRAME_W), .SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk (clk),
    .rstN(rstN),
    .csN (csN),
    .sclk(sclk),
    .din (din),
    .clrN(clrN),
    .stb (stb)
  );

  serdac_datapath #(.DATA_W(DATA_W), .UPO_DEFAULT(UPO_DEFAULT)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .dout     (dout),
    .upo      (upo),
    .powerDown(powerDown),
    .inputReg (inputReg),
    .dacReg   (dacReg)
  );
endmodule

// File: tb/serdac_if_tb.sv
`timescale 1ns/1ps
module serdac_if_tb_top;
  localparam int HP = 10;  // sclk half period in system clocks

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, sclk = 1'b0, din = 1'b0, clrN = 1'b1;
  logic dout, upo, powerDown;
  logic [12:0] inputReg, dacReg;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic cap [1:32];

  always #2.5 clk = ~clk;

  serdac_if dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .din(din), .clrN(clrN),
    .dout(dout), .upo(upo), .powerDown(powerDown),
    .inputReg(inputReg), .dacReg(dacReg)
  );

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input logic [2:0] c, input logic [12:0] d);
    return {c, d};
  endfunction

  // Sends n bits MSB-first from word[n-1:0]; cap[k] is dout mid-high after edge k
  task automatic sendBits(input logic [31:0] word, input int n);
    csN = 1'b0;
    hold(HP);
    for (int i = n - 1; i >= 0; i--) begin
      din = word[i];
      hold(HP);
      sclk = 1'b1;
      hold(HP / 2);
      cap[n - i] = dout;
      hold(HP / 2);
      sclk = 1'b0;
    end
    hold(HP);
    csN = 1'b1;
    hold(2 * HP + 4);
  endtask

  task automatic t_reset;
    chk(dout == 1'b0, "R1 dout", 32'(dout), 0);
    chk(upo == 1'b0, "R1 upo", 32'(upo), 0);
    chk(powerDown == 1'b0, "R1 powerDown", 32'(powerDown), 0);
    chk(inputReg == 0 && dacReg == 0, "R1 registers", {inputReg, 3'b0, dacReg}, 0);
  endtask

  task automatic t_load_input;
    sendBits(32'(mk(3'b001, 13'h1ABC)), 16);
    chk(inputReg == 13'h1ABC, "R2 inputReg", 32'(inputReg), 32'h1ABC);
    chk(dacReg == 13'h0, "R2 dacReg untouched", 32'(dacReg), 0);
  endtask

  task automatic t_load_both;
    sendBits(32'(mk(3'b010, 13'h0555)), 16);
    chk(inputReg == 13'h0555 && dacReg == 13'h0555, "R3 both registers",
        {inputReg, 3'b0, dacReg}, {13'h0555, 3'b0, 13'h0555});
  endtask

  task automatic t_xfer;
    sendBits(32'(mk(3'b001, 13'h1234)), 16);
    chk(dacReg == 13'h0555, "R4 dac held before transfer", 32'(dacReg), 32'h0555);
    sendBits(32'(mk(3'b011, 13'h0000)), 16);
    chk(dacReg == 13'h1234, "R4 dac after transfer", 32'(dacReg), 32'h1234);
    chk(inputReg == 13'h1234, "R4 input kept", 32'(inputReg), 32'h1234);
  endtask

  task automatic t_noop;
    sendBits(32'(mk(3'b000, 13'h1FFF)), 16);
    chk(inputReg == 13'h1234 && dacReg == 13'h1234, "R12 no-op",
        {inputReg, 3'b0, dacReg}, {13'h1234, 3'b0, 13'h1234});
  endtask

  task automatic t_bad_length;
    sendBits(32'(mk(3'b010, 13'h0F0F)) >> 1, 15);
    chk(inputReg == 13'h1234 && dacReg == 13'h1234, "R5 short frame",
        {inputReg, 3'b0, dacReg}, {13'h1234, 3'b0, 13'h1234});
    sendBits({15'b0, mk(3'b010, 13'h0F0F), 1'b0}, 17);
    chk(inputReg == 13'h1234 && dacReg == 13'h1234, "R5 long frame",
        {inputReg, 3'b0, dacReg}, {13'h1234, 3'b0, 13'h1234});
  endtask

  task automatic t_mode0_lag;
    logic [15:0] x;
    bit ok;
    x = mk(3'b000, 13'h0A5C);
    sendBits(32'(x), 16);
    sendBits(32'(mk(3'b000, 13'h0000)), 16);
    ok = 1;
    for (int k = 1; k <= 16; k++) if (cap[k] !== x[16 - k]) ok = 0;
    chk(ok, "R6 falling-edge echo lag 16", 32'(cap[2]), 32'(x[14]));
  endtask

  task automatic t_mode1_lag;
    logic [15:0] m;
    bit ok;
    m = mk(3'b100, 13'h1333);
    sendBits(32'(m), 16);
    sendBits(32'(mk(3'b000, 13'h0000)), 16);
    ok = 1;
    for (int k = 1; k <= 15; k++) if (cap[k] !== m[15 - k]) ok = 0;
    chk(ok, "R7 rising-edge echo lag 15.5", 32'(cap[1]), 32'(m[14]));
    sendBits(32'(mk(3'b100, 13'h0000)), 16);
    sendBits(32'(mk(3'b000, 13'h0000)), 16);
    chk(cap[1] == 1'b1 && cap[2] == 1'b0, "R7 back to falling-edge mode",
        {cap[1], cap[2]}, 2'b10);
  endtask

  task automatic t_upo;
    sendBits(32'(mk(3'b101, 13'h1000)), 16);
    chk(upo == 1'b1, "R8 upo set", 32'(upo), 1);
    sendBits(32'(mk(3'b101, 13'h0FFF)), 16);
    chk(upo == 1'b0, "R8 upo clear", 32'(upo), 0);
    sendBits(32'(mk(3'b101, 13'h1000)), 16);
  endtask

  task automatic t_powerdown;
    logic d0;
    bit ok;
    sendBits(32'(mk(3'b110, 13'h0000)), 16);
    chk(powerDown == 1'b1, "R9 powerDown set", 32'(powerDown), 1);
    d0 = dout;
    sendBits(32'(mk(3'b101, 13'h0000)), 16);
    ok = 1;
    for (int k = 1; k <= 16; k++) if (cap[k] !== d0) ok = 0;
    chk(ok && dout == d0, "R9 dout frozen", 32'(cap[3]), 32'(d0));
    chk(upo == 1'b1, "R9 upo frozen", 32'(upo), 1);
  endtask

  task automatic t_wake;
    clrN = 1'b1;
    sendBits(32'(mk(3'b111, 13'h0000)), 16);
    chk(powerDown == 1'b0, "R10 wake clears powerDown", 32'(powerDown), 0);
    chk(upo == 1'b1, "R10 upo kept with clear high", 32'(upo), 1);
    sendBits(32'(mk(3'b110, 13'h0000)), 16);
    clrN = 1'b0;
    sendBits(32'(mk(3'b111, 13'h0000)), 16);
    clrN = 1'b1;
    chk(upo == 1'b0, "R10 upo default with clear low", 32'(upo), 0);
    chk(powerDown == 1'b0, "R10 awake again", 32'(powerDown), 0);
  endtask

  task automatic t_cs_idle;
    logic d0;
    d0 = dout;
    for (int i = 0; i < 20; i++) begin
      din = i[0];
      sclk = 1'b1;
      hold(HP);
      chk(dout == d0, "R11 dout held while deselected", 32'(dout), 32'(d0));
      sclk = 1'b0;
      hold(HP);
    end
    sendBits(32'(mk(3'b001, 13'h0F0F)), 16);
    chk(inputReg == 13'h0F0F, "R11 frame intact after idle clocks",
        32'(inputReg), 32'h0F0F);
  endtask

  initial begin
    hold(5);
    rstN = 1'b1;
    hold(5);
    t_reset();
    t_load_input();
    t_load_both();
    t_xfer();
    t_noop();
    t_bad_length();
    t_mode0_lag();
    t_mode1_lag();
    t_upo();
    t_powerdown();
    t_wake();
    t_cs_idle();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule